// File: doc/BRIEF.md
# Three-Wire Configuration Register Bank

This block takes configuration words from a slow three-wire serial bus (a data line, a bit clock and a latch strobe) and stores them in four small configuration registers. Together, those registers control a frequency synthesizer and an IF signal chain. They hold three divider values (main, swallow and reference), two test-path selects with an enable for the test path, an enable for the reference clock output, and the IF filter mode. Every bus line is brought into the system clock domain through a synchronizer. All edges are then detected on the system clock.

A frame is 18 bits long and is sent least significant data bit first. The two address bits come last. The shifted word is committed only on a rising edge of the latch strobe, and only when exactly 18 bit-clock rising edges came before it. If any other count came before the strobe, the frame is dropped.

While `enable` is low, every register is cleared and bus activity is ignored. When `enable` rises, the bank loads one of three preset profiles, picked by the static levels on the three bus lines at that moment. These presets give a working configuration without any serial writes. The two test selects are also decoded into one-hot tap vectors. These vectors fall back to normal operation for unused codes, and also whenever the test path is disabled.

Top module: `cfg3w_bank`

## Requirements
- R1: A frame is 18 bits, sampled on rising edges of `bus_clk`. The first bit received is data bit D0, then D1 up to D15, then address bit A0, and address bit A1 is the last bit.
- R2: Field layout by address {A1,A0}:
  - Address 0: `main_div` = D10..D0.
  - Address 1: `ref_div` = D8..D0 and `swal_div` = D13..D9.
  - Address 2: `tin_sel` = D2..D0, `test_en` = D3 and `clkout_en` = D4.
  - Address 3: `tout_sel` = D2..D0 and `filt_bp` = D3, where 1 selects band-pass and 0 selects low-pass.
- R3: A latch rising edge that follows any number of bit-clock rising edges other than 18 changes no register. The next frame then starts counting from zero.
- R4: Shifting bits alone changes no output. A frame takes effect only on the latch rising edge.
- R5: A rising edge of `enable` loads the profile selected by ({`bus_dat`,`bus_clk`,`bus_lat`}):
  - 000 loads main 6, swallow 0, ref 3, band-pass, `test_en` 1, both test selects 110 and clock output off. This gives a 1571.328 MHz synthesizer frequency from 16.368 MHz, with a 4.092 MHz IF.
  - 100 loads main 7, swallow 3, ref 4, low-pass, test path off and clock output off. This gives 1574.397 MHz from 18.414 MHz.
  - 110 loads main 22, swallow 17, ref 9, low-pass, test path off and clock output off. This gives 1574.444 MHz from 13 MHz.
- R6: Any other strap combination loads the 000 profile.
- R7: The one-hot taps use bits 0..4 for codes 001, 010, 101, 110 and 111 of a select. Code 000, the unused codes 011 and 100, and any code while `test_en` is 0 all give an all-zero tap vector (normal operation).
- R8: While `enable` is low, every register field reads zero and bus frames have no effect.
- R9: A committed frame changes only the fields of its own address. All other fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Part enable; its rising edge loads a preset |
| bus_dat | input | 1 | Serial data line; also a preset strap |
| bus_clk | input | 1 | Serial bit clock; also a preset strap |
| bus_lat | input | 1 | Latch strobe; also a preset strap |
| main_div | output | 11 | Main counter division value |
| swal_div | output | 5 | Swallow counter division value |
| ref_div | output | 9 | Reference counter division value |
| tin_sel | output | 3 | Raw test-input select |
| tout_sel | output | 3 | Raw test-output select |
| test_en | output | 1 | Test path enable |
| clkout_en | output | 1 | Reference clock output enable |
| filt_bp | output | 1 | IF filter mode, 1 = band-pass |
| tin_tap | output | 5 | One-hot decoded test-input tap |
| tout_tap | output | 5 | One-hot decoded test-output tap |

## Verification
The assertions check a set of rules on every cycle:
- Tap vectors are at most one-hot and are silent while the test path is off.
- The register fields clear while `enable` is low.
- The stored configuration holds steady in any cycle without a commit or an enable edge.
- A latch edge always restarts the bit counter.
- A preset always has a legal reference divider.

The bench's scenarios are needed for the rest:
- the exact bit order and field positions;
- dropping 17- and 19-bit frames;
- the strap-to-profile mapping, with each preset's synthesizer frequency recomputed from the read-back dividers;
- ignoring frames while disabled.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;

    localparam int FRAME_W  = 18;
    localparam int ADDR_W   = 2;
    localparam int MAIN_W   = 11;
    localparam int SWAL_W   = 5;
    localparam int REF_W    = 9;
    localparam int SEL_W    = 3;
    localparam int TAP_N    = 5;
    localparam int STRAP_W  = 3;
    localparam int USED_W   = SWAL_W + REF_W;
    localparam int CNT_W    = $clog2(FRAME_W + 2);
    localparam int CNT_MAX  = FRAME_W + 1;

    // bit positions inside the data part of a frame
    localparam int SWAL_LSB = REF_W;
    localparam int TEN_BIT  = SEL_W;
    localparam int CLKO_BIT = SEL_W + 1;
    localparam int FILT_BIT = SEL_W;

    typedef struct packed {
        logic [MAIN_W-1:0] main_div;
        logic [SWAL_W-1:0] swal_div;
        logic [REF_W-1:0]  ref_div;
        logic [SEL_W-1:0]  tin_sel;
        logic [SEL_W-1:0]  tout_sel;
        logic              test_en;
        logic              clkout_en;
        logic              filt_bp;
    } cfg_t;

    typedef enum logic [1:0] {
        PROF_IF4  = 2'd0,
        PROF_IF1  = 2'd1,
        PROF_R13  = 2'd2
    } profile_e;

    function automatic profile_e strap_to_profile(input logic [STRAP_W-1:0] strap);
        profile_e p;
        case (strap)
            3'b100:  p = PROF_IF1;
            3'b110:  p = PROF_R13;
            default: p = PROF_IF4;
        endcase
        return p;
    endfunction

    function automatic cfg_t profile_cfg(input profile_e p);
        cfg_t c;
        c = '0;
        case (p)
            PROF_IF1: begin
                c.main_div = MAIN_W'(7);
                c.swal_div = SWAL_W'(3);
                c.ref_div  = REF_W'(4);
            end
            PROF_R13: begin
                c.main_div = MAIN_W'(22);
                c.swal_div = SWAL_W'(17);
                c.ref_div  = REF_W'(9);
            end
            default: begin
                c.main_div = MAIN_W'(6);
                c.swal_div = SWAL_W'(0);
                c.ref_div  = REF_W'(3);
                c.filt_bp  = 1'b1;
                c.test_en  = 1'b1;
                c.tin_sel  = SEL_W'(6);
                c.tout_sel = SEL_W'(6);
            end
        endcase
        return c;
    endfunction

    // select code that drives tap k: 1,2,5,6,7
    function automatic logic [SEL_W-1:0] tap_code(input int k);
        return (k < 2) ? SEL_W'(k + 1) : SEL_W'(k + 3);
    endfunction

endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/cfg3w_shifter.sv
module cfg3w_shifter
    import cfg3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              dat_i,
    input  logic              bclk_i,
    input  logic              lat_i,
    output logic              commit_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [USED_W-1:0] data_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic [CNT_W-1:0]   cnt;
        logic               bclk_prev;
        logic               lat_prev;
    } shf_t;

    shf_t st_d, st_q;
    logic bclk_rise, lat_rise;

    assign bclk_rise = bclk_i & ~st_q.bclk_prev;
    assign lat_rise  = lat_i & ~st_q.lat_prev;

    always_comb begin
        st_d           = st_q;
        st_d.bclk_prev = bclk_i;
        st_d.lat_prev  = lat_i;
        if (!run_i) begin
            st_d.sr  = '0;
            st_d.cnt = '0;
        end else if (lat_rise) begin
            st_d.cnt = '0;
        end else if (bclk_rise) begin
            st_d.sr = {dat_i, st_q.sr[FRAME_W-1:1]};
            if (st_q.cnt != CNT_W'(CNT_MAX)) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit_o = run_i && lat_rise && (st_q.cnt == CNT_W'(FRAME_W));
    assign addr_o   = st_q.sr[FRAME_W-1 -: ADDR_W];
    assign data_o   = st_q.sr[USED_W-1:0];

    // R3: the pulse counter never runs past its saturation value
    assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(CNT_MAX));

    // R3: every latch edge restarts the count for the next frame
    assert_cnt_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && lat_rise) |=> (st_q.cnt == '0));

endmodule

// File: rtl/cfg3w_regfile.sv
module cfg3w_regfile
    import cfg3w_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               commit_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [USED_W-1:0]  data_i,
    output cfg_t               cfg_o
);
    typedef struct packed {
        cfg_t cfg;
        logic en_prev;
    } rf_t;

    rf_t  st_d, st_q;
    logic en_rise;

    assign en_rise = en_i & ~st_q.en_prev;

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = en_i;
        if (!en_i) begin
            st_d.cfg = '0;
        end else if (en_rise) begin
            st_d.cfg = profile_cfg(strap_to_profile(strap_i));
        end else if (commit_i) begin
            case (addr_i)
                2'd0: begin
                    st_d.cfg.main_div = data_i[MAIN_W-1:0];
                end
                2'd1: begin
                    st_d.cfg.ref_div  = data_i[REF_W-1:0];
                    st_d.cfg.swal_div = data_i[SWAL_LSB +: SWAL_W];
                end
                2'd2: begin
                    st_d.cfg.tin_sel   = data_i[SEL_W-1:0];
                    st_d.cfg.test_en   = data_i[TEN_BIT];
                    st_d.cfg.clkout_en = data_i[CLKO_BIT];
                end
                default: begin
                    st_d.cfg.tout_sel = data_i[SEL_W-1:0];
                    st_d.cfg.filt_bp  = data_i[FILT_BIT];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_o = st_q.cfg;

    // R8: a disabled part holds every field cleared
    assert_off_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (st_q.cfg == '0));

    // R9: without a commit or an enable edge nothing moves
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && st_q.en_prev && !commit_i) |=> $stable(st_q.cfg));

    // R5: every preset carries a legal reference divider (3 or more)
    assert_preset_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> (st_q.cfg.ref_div >= REF_W'(3)));

endmodule

// File: rtl/cfg3w_tapdec.sv
module cfg3w_tapdec
    import cfg3w_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    input  logic             en_i,
    output logic [TAP_N-1:0] tap_o
);
    for (genvar k = 0; k < TAP_N; k++) begin : g_tap
        assign tap_o[k] = en_i && (sel_i == tap_code(k));
    end

endmodule

// File: rtl/cfg3w_bank.sv
module cfg3w_bank
    import cfg3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bus_dat,
    input  logic              bus_clk,
    input  logic              bus_lat,
    output logic [MAIN_W-1:0] main_div,
    output logic [SWAL_W-1:0] swal_div,
    output logic [REF_W-1:0]  ref_div,
    output logic [SEL_W-1:0]  tin_sel,
    output logic [SEL_W-1:0]  tout_sel,
    output logic              test_en,
    output logic              clkout_en,
    output logic              filt_bp,
    output logic [TAP_N-1:0]  tin_tap,
    output logic [TAP_N-1:0]  tout_tap
);
    logic [3:0]        pins_s;
    logic              en_s, dat_s, bclk_s, lat_s;
    logic              commit;
    logic [ADDR_W-1:0] f_addr;
    logic [USED_W-1:0] f_data;
    cfg_t              cfg;

    cfg3w_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({enable, bus_dat, bus_clk, bus_lat}),
        .sync_o  (pins_s)
    );

    assign {en_s, dat_s, bclk_s, lat_s} = pins_s;

    cfg3w_shifter u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (en_s),
        .dat_i    (dat_s),
        .bclk_i   (bclk_s),
        .lat_i    (lat_s),
        .commit_o (commit),
        .addr_o   (f_addr),
        .data_o   (f_data)
    );

    cfg3w_regfile u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_s),
        .strap_i  ({dat_s, bclk_s, lat_s}),
        .commit_i (commit),
        .addr_i   (f_addr),
        .data_i   (f_data),
        .cfg_o    (cfg)
    );

    cfg3w_tapdec u_tin (
        .sel_i (cfg.tin_sel),
        .en_i  (cfg.test_en),
        .tap_o (tin_tap)
    );

    cfg3w_tapdec u_tout (
        .sel_i (cfg.tout_sel),
        .en_i  (cfg.test_en),
        .tap_o (tout_tap)
    );

    assign main_div  = cfg.main_div;
    assign swal_div  = cfg.swal_div;
    assign ref_div   = cfg.ref_div;
    assign tin_sel   = cfg.tin_sel;
    assign tout_sel  = cfg.tout_sel;
    assign test_en   = cfg.test_en;
    assign clkout_en = cfg.clkout_en;
    assign filt_bp   = cfg.filt_bp;

    // R7: at most one tap point is ever selected on each side
    assert_tap_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tin_tap) && $onehot0(tout_tap));

    // R7: test path disabled means normal operation on both sides
    assert_tap_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |-> (tin_tap == '0 && tout_tap == '0));

endmodule

// File: tb/sim_cfg3w_bank.sv
module sim_cfg3w_bank;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4;

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
    logic bus_dat = 1'b0, bus_clk = 1'b0, bus_lat = 1'b0;
    logic [10:0] main_div;
    logic [4:0]  swal_div, tin_tap, tout_tap;
    logic [8:0]  ref_div;
    logic [2:0]  tin_sel, tout_sel;
    logic        test_en, clkout_en, filt_bp;

    int n_chk = 0, n_fail = 0;
    logic [10:0] e_main;
    logic [4:0]  e_swal;
    logic [8:0]  e_ref;
    logic [2:0]  e_tin, e_tout;
    logic        e_ten, e_clko, e_filt;

    cfg3w_bank u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .bus_dat(bus_dat), .bus_clk(bus_clk), .bus_lat(bus_lat),
        .main_div(main_div), .swal_div(swal_div), .ref_div(ref_div),
        .tin_sel(tin_sel), .tout_sel(tout_sel), .test_en(test_en),
        .clkout_en(clkout_en), .filt_bp(filt_bp),
        .tin_tap(tin_tap), .tout_tap(tout_tap)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_tap(input logic [2:0] s, input logic en);
        if (!en) return 5'd0;
        case (s)
            3'd1: return 5'b00001;
            3'd2: return 5'b00010;
            3'd5: return 5'b00100;
            3'd6: return 5'b01000;
            3'd7: return 5'b10000;
            default: return 5'd0;
        endcase
    endfunction

    task automatic check_all(input string req);
        chk(req, "main_div", 32'(main_div), 32'(e_main));
        chk(req, "swal_div", 32'(swal_div), 32'(e_swal));
        chk(req, "ref_div", 32'(ref_div), 32'(e_ref));
        chk(req, "ctrl", {22'd0, tin_sel, tout_sel, test_en, clkout_en, filt_bp},
            {22'd0, e_tin, e_tout, e_ten, e_clko, e_filt});
        chk(req, "taps", {22'd0, tin_tap, tout_tap},
            {22'd0, exp_tap(e_tin, e_ten), exp_tap(e_tout, e_ten)});
    endtask

    task automatic clear_exp();
        e_main = '0; e_swal = '0; e_ref = '0; e_tin = '0; e_tout = '0;
        e_ten = 1'b0; e_clko = 1'b0; e_filt = 1'b0;
    endtask

    task automatic set_exp_profile(input logic [2:0] s);
        clear_exp();
        if (s == 3'b100) begin
            e_main = 11'd7; e_swal = 5'd3; e_ref = 9'd4;
        end else if (s == 3'b110) begin
            e_main = 11'd22; e_swal = 5'd17; e_ref = 9'd9;
        end else begin
            e_main = 11'd6; e_ref = 9'd3; e_filt = 1'b1;
            e_ten = 1'b1; e_tin = 3'd6; e_tout = 3'd6;
        end
    endtask

    task automatic shift_bits(input logic [17:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            bus_dat = (i < 18) ? w[i] : 1'b0;
            wait_cyc(HOLD);
            bus_clk = 1'b1;
            wait_cyc(HOLD);
            bus_clk = 1'b0;
        end
        bus_dat = 1'b0;
        wait_cyc(HOLD);
    endtask

    task automatic pulse_latch();
        bus_lat = 1'b1;
        wait_cyc(HOLD);
        bus_lat = 1'b0;
        wait_cyc(HOLD);
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
        shift_bits({a, d}, 18);
        pulse_latch();
        case (a)
            2'd0: e_main = d[10:0];
            2'd1: begin e_ref = d[8:0]; e_swal = d[13:9]; end
            2'd2: begin e_tin = d[2:0]; e_ten = d[3]; e_clko = d[4]; end
            default: begin e_tout = d[2:0]; e_filt = d[3]; end
        endcase
    endtask

    task automatic power_up(input logic [2:0] s);
        enable = 1'b0;
        wait_cyc(HOLD * 2);
        {bus_dat, bus_clk, bus_lat} = s;
        wait_cyc(HOLD);
        enable = 1'b1;
        wait_cyc(HOLD * 2);
        {bus_dat, bus_clk, bus_lat} = 3'b000;
        wait_cyc(HOLD * 2);
        set_exp_profile(s);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        clear_exp();
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(6);
        check_all("R8");

        // R5/R6: every strap combination, and recompute the synthesizer frequency
        for (int s = 0; s < 8; s++) begin
            int ft, ifk;
            power_up(3'(s));
            check_all((s == 0 || s == 4 || s == 6) ? "R5" : "R6");
            ft  = (s == 4) ? 18414 : (s == 6) ? 13000 : 16368;
            ifk = (s == 4) ? 1023  : (s == 6) ? 976   : 4092;
            if (ref_div != 0)
                chk("R5", "fvco_khz",
                    32'((24 * int'(main_div) + int'(swal_div)) * 2 * ft / int'(ref_div)),
                    32'(1575420 - ifk));
            else
                chk("R5", "ref_div_nonzero", 32'(0), 32'(1));
        end

        power_up(3'b100);
        // R1/R2: walking one through each divider field
        for (int k = 0; k < 11; k++) begin
            write_reg(2'd0, 16'(1 << k));
            check_all("R1");
        end
        for (int k = 0; k < 14; k++) begin
            write_reg(2'd1, 16'(1 << k));
            check_all("R2");
        end
        // R9: other addresses keep their contents
        write_reg(2'd0, 16'h0555);
        write_reg(2'd1, 16'h2AB3);
        write_reg(2'd0, 16'h02AA);
        check_all("R9");

        // R7: all select codes with the test path on and off
        for (int c = 0; c < 8; c++) begin
            for (int e = 0; e < 2; e++) begin
                write_reg(2'd2, {11'd0, 1'(c), 1'(e), 3'(c)});
                write_reg(2'd3, {12'd0, 1'(c >> 1), 3'(7 - c)});
                check_all("R7");
            end
        end

        // R4: shifting alone has no effect until the latch edge
        shift_bits({2'b00, 16'h0123}, 18);
        check_all("R4");
        pulse_latch();
        e_main = 11'h123;
        check_all("R4");

        // R3: short and long frames are dropped
        shift_bits({2'b00, 16'h0456}, 17);
        pulse_latch();
        check_all("R3");
        shift_bits({2'b00, 16'h0456}, 19);
        pulse_latch();
        check_all("R3");
        write_reg(2'd0, 16'h0456);
        check_all("R3");

        // R8: disabled part clears and ignores frames
        enable = 1'b0;
        wait_cyc(HOLD * 2);
        clear_exp();
        check_all("R8");
        shift_bits({2'b01, 16'h1FFF}, 18);
        pulse_latch();
        check_all("R8");
        power_up(3'b110);
        check_all("R5");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule